// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-bit register with four clocked behaviours: it keeps its value, shifts toward its high end, shifts toward its low end, or takes a whole byte from its parallel port. A two-bit mode input picks the behaviour, and the register acts on each rising clock edge. An active-low clear empties the register at once, without waiting for the clock.

The parallel port is meant to sit on a shared bidirectional bus. Here the bus is split into three signals: an input byte, an output byte and one output-enable. A pad wrapper can build the tristate from these. The register drives the bus only when both of its active-low enables are low and the mode is not load. In load mode the bus is left free so that an outside agent can supply the byte. Two serial outputs always show the lowest and the highest bit, whatever the enables are, so that several registers can be chained.

Top module: `usr_bidir`

## Requirements
- R1: While `clr_n` is low, all eight bits, `ser_lo_out` and `ser_hi_out` are 0. The clear acts at once, without a clock edge.
- R2: Mode 2'b00 (hold): a rising edge leaves every bit unchanged.
- R3: Mode 2'b01 (shift up): on a rising edge, bit i+1 takes the old bit i, and bit 0 takes `ser_up_in`.
- R4: Mode 2'b10 (shift down): on a rising edge, bit i takes the old bit i+1, and bit 7 takes `ser_dn_in`.
- R5: Mode 2'b11 (load): on a rising edge, bit i takes `par_in[i]`. In every other mode `par_in` has no effect.
- R6: `par_oe` is 1 exactly when `en_a_n` and `en_b_n` are both 0 and `mode` is not 2'b11. It is combinational.
- R7: The enables do not affect holding, shifting, loading or clearing. `par_out` always shows the register contents.
- R8: `ser_lo_out` equals bit 0 and `ser_hi_out` equals bit 7, whatever the enables are.
- R9: A clock edge that arrives while `clr_n` is low leaves the register at 0. The first rising edge after `clr_n` goes high performs the selected mode.
- R10: The register changes only on a rising clock edge or on clear. A change of the inputs between edges does not move `par_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register acts on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| en_a_n | input | 1 | Bus output enable A, active low |
| en_b_n | input | 1 | Bus output enable B, active low |
| ser_up_in | input | 1 | Serial bit entering bit 0 during a shift up |
| ser_dn_in | input | 1 | Serial bit entering bit 7 during a shift down |
| par_in | input | 8 | Byte taken from the shared bus in load mode |
| par_out | output | 8 | Register contents toward the shared bus |
| par_oe | output | 1 | High when the register may drive the bus |
| ser_lo_out | output | 1 | Bit 0, always driven |
| ser_hi_out | output | 1 | Bit 7, always driven |

## Verification
On every clock edge the assertions check the next-state rule of each mode against the previous cycle. They also check that the bus enable stays off in load mode and while an enable is high, and that the register sits at zero under clear. Only the bench's scenarios can show the timing of clear: that it takes effect in the middle of a cycle, and that the first edge after release acts. The same holds for the register staying still between edges, and for the serial outputs and the shifts keeping their values through every combination of enables.

// File: rtl/usr_pkg.sv
package usr_pkg;
  localparam int unsigned USR_WIDTH = 8;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int unsigned WIDTH = USR_WIDTH
) (
  input  logic [WIDTH-1:0] cur_q,
  input  usr_mode_e        mode,
  input  logic             ser_up_in,
  input  logic             ser_dn_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] nxt_q,
  output logic             upd_en
);
  localparam int unsigned TOP = WIDTH - 1;

  // each bit picks from its lower neighbour, upper neighbour or the bus
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;

    if (i == 0) begin : g_low_end
      assign from_below = ser_up_in;
    end else begin : g_low_mid
      assign from_below = cur_q[i-1];
    end

    if (i == TOP) begin : g_high_end
      assign from_above = ser_dn_in;
    end else begin : g_high_mid
      assign from_above = cur_q[i+1];
    end

    always_comb begin
      unique case (mode)
        MODE_UP:   nxt_q[i] = from_below;
        MODE_DOWN: nxt_q[i] = from_above;
        MODE_LOAD: nxt_q[i] = par_in[i];
        default:   nxt_q[i] = cur_q[i];
      endcase
    end
  end

  // hold is realised as a clock enable rather than a feedback mux path
  always_comb begin
    upd_en = (mode != MODE_HOLD);
  end
endmodule

// File: rtl/usr_state_reg.sv
module usr_state_reg #(
  parameter int unsigned WIDTH = usr_pkg::USR_WIDTH
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             upd_en,
  input  logic [WIDTH-1:0] nxt_q,
  output logic [WIDTH-1:0] cur_q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cur_q <= '0;
    end else if (upd_en) begin
      cur_q <= nxt_q;
    end
  end

  // R2: without the update enable the stored word does not move
  assert_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !upd_en |=> (cur_q == $past(cur_q)));

  // R1: under clear the register reads zero at every edge
  assert_clear_R1: assert property (@(posedge clk)
    !clr_n |-> (cur_q == '0));
endmodule

// File: rtl/usr_drive_ctl.sv
module usr_drive_ctl
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      clr_n,
  input  usr_mode_e mode,
  input  logic      en_a_n,
  input  logic      en_b_n,
  output logic      par_oe
);
  logic both_enabled;
  logic bus_free;

  always_comb begin
    both_enabled = ~(en_a_n | en_b_n);
    bus_free     = (mode == MODE_LOAD);
    par_oe       = both_enabled & ~bus_free;
  end

  // R6: load mode never drives the bus
  assert_oe_load_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_LOAD) |-> !par_oe);

  // R6: a raised enable always releases the bus
  assert_oe_enable_R6: assert property (@(posedge clk) disable iff (!clr_n)
    par_oe |-> (!en_a_n && !en_b_n));
endmodule

// File: rtl/usr_bidir.sv
module usr_bidir
  import usr_pkg::*;
#(
  parameter int unsigned WIDTH = USR_WIDTH
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode,
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic             ser_up_in,
  input  logic             ser_dn_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out,
  output logic             par_oe,
  output logic             ser_lo_out,
  output logic             ser_hi_out
);
  localparam int unsigned TOP = WIDTH - 1;

  usr_mode_e        mode_e;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] nxt_q;
  logic             upd_en;

  assign mode_e = usr_mode_e'(mode);

  usr_next_state #(.WIDTH(WIDTH)) u_next (
    .cur_q     (cur_q),
    .mode      (mode_e),
    .ser_up_in (ser_up_in),
    .ser_dn_in (ser_dn_in),
    .par_in    (par_in),
    .nxt_q     (nxt_q),
    .upd_en    (upd_en)
  );

  usr_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk    (clk),
    .clr_n  (clr_n),
    .upd_en (upd_en),
    .nxt_q  (nxt_q),
    .cur_q  (cur_q)
  );

  usr_drive_ctl u_drv (
    .clk    (clk),
    .clr_n  (clr_n),
    .mode   (mode_e),
    .en_a_n (en_a_n),
    .en_b_n (en_b_n),
    .par_oe (par_oe)
  );

  assign par_out    = cur_q;
  assign ser_lo_out = cur_q[0];
  assign ser_hi_out = cur_q[TOP];

  // R3: shift up moves every bit one place higher and takes the serial bit at 0
  assert_shift_up_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b01) |=> (par_out == {$past(par_out[TOP-1:0]), $past(ser_up_in)}));

  // R4: shift down moves every bit one place lower and takes the serial bit at 7
  assert_shift_down_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b10) |=> (par_out == {$past(ser_dn_in), $past(par_out[TOP:1])}));

  // R5: load copies the bus into the register
  assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |=> (par_out == $past(par_in)));
endmodule

// File: tb/tb_usr_bidir.sv
module tb_usr_bidir;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // row: mode[22:21] en_a_n[20] en_b_n[19] up[18] dn[17] par_in[16:9] exp_q[8:1] exp_oe[0]
  localparam logic [22:0] VEC [NVEC] = '{
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0},
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h4B, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h96, 1'b0},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hCB, 1'b1},
    {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h65, 1'b0},
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 8'h81, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h81, 1'b0},
    {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h03, 1'b1},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1},
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1}
  };

  logic       clk = 1'b0;
  logic       clr_n;
  logic [1:0] mode;
  logic       en_a_n, en_b_n, ser_up_in, ser_dn_in;
  logic [7:0] par_in, par_out;
  logic       par_oe, ser_lo_out, ser_hi_out;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] prev_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  usr_bidir dut (
    .clk(clk), .clr_n(clr_n), .mode(mode), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .ser_up_in(ser_up_in), .ser_dn_in(ser_dn_in), .par_in(par_in),
    .par_out(par_out), .par_oe(par_oe), .ser_lo_out(ser_lo_out), .ser_hi_out(ser_hi_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] want);
    n_checks++;
    if (got !== want) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, want, $time);
    end
  endtask

  task automatic check_q(input string req, input logic [7:0] want);
    check(req, par_out, want);
    check({req, "/R8 lo"}, {7'd0, ser_lo_out}, {7'd0, want[0]});
    check({req, "/R8 hi"}, {7'd0, ser_hi_out}, {7'd0, want[7]});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin : main
    clr_n = 1'b1; mode = 2'b00; en_a_n = 1'b1; en_b_n = 1'b1;
    ser_up_in = 1'b0; ser_dn_in = 1'b0; par_in = 8'h00;
    #2 clr_n = 1'b0;
    #1;
    // R1: reset state
    check_q("R1 reset", 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    clr_n = 1'b1;
    prev_q = 8'h00;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      {mode, en_a_n, en_b_n, ser_up_in, ser_dn_in, par_in} = VEC[k][22:9];
      #1;
      check("R6 oe", {7'd0, par_oe}, {7'd0, VEC[k][0]});
      check("R10 no move between edges", par_out, prev_q);
      @(posedge clk);
      #1;
      check_q($sformatf("R2-5/R7 row %0d", k), VEC[k][8:1]);
      prev_q = VEC[k][8:1];
    end

    // R5: par_in has no effect outside load (hold with noisy bus)
    @(negedge clk);
    mode = 2'b00; en_a_n = 1'b0; en_b_n = 1'b0; par_in = 8'hFF;
    @(posedge clk); #1;
    check_q("R5 bus ignored in hold", 8'h00);

    // R1 R9: clear in mid-cycle, held across an edge while loading
    @(negedge clk);
    mode = 2'b11; par_in = 8'hFF;
    @(posedge clk); #1;
    check_q("R5 load FF", 8'hFF);
    #2 clr_n = 1'b0;
    #1;
    check_q("R1 mid-cycle clear", 8'h00);
    @(posedge clk); #1;
    check_q("R9 edge under clear", 8'h00);
    @(negedge clk);
    clr_n = 1'b1; par_in = 8'h5A;
    @(posedge clk); #1;
    check_q("R9 first edge after release", 8'h5A);

    // R7: clear also works with enables raised; R6 oe low then
    @(negedge clk);
    mode = 2'b00; en_a_n = 1'b1; en_b_n = 1'b1;
    #1;
    check("R6 oe enables high", {7'd0, par_oe}, 8'h00);
    clr_n = 1'b0;
    #1;
    check_q("R7 clear with enables high", 8'h00);
    @(negedge clk);
    clr_n = 1'b1;
    @(posedge clk); #1;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule